// File: doc/BRIEF.md
# Serial Pattern-Unlock Access Sequencer

This block watches the cycle stream of a byte-wide memory bus and decides, cycle by cycle, whether an access belongs to the memory array or to a hidden timekeeping register image. Each bus access reaches the block as a one-clock read or write strobe, together with its address and data bit 0. Until a fixed 64-bit unlock key has arrived serially on data bit 0, every access goes to memory. The key must come in over consecutive write cycles that fall inside a low address window. Any read inside that window restarts recognition. One wrong key bit freezes recognition until the next such read.

Once the last key bit matches, the block captures the current clock registers into a 64-bit shadow. It then claims the next 64 in-window cycles and raises a memory-inhibit flag for each of them. A read cycle returns one shadow bit, least significant bit first and starting from register 0. A write cycle replaces one shadow bit. After the 64th cycle the block presents the shadow, with a byte mask of the bytes that were fully written, for a single-cycle load strobe. It then goes back to waiting for the key. Cycles whose address lies outside the window pass through untouched in every phase.

Top module: `pattern_unlock_seq`

## Requirements
- R1: A synchronous active-low reset leaves the block waiting for key bit 0 with recognition enabled, and with `mem_inhibit`, `rd_bit` and `load_stb` low, `image_out` zero and `byte_mask` zero.
- R2: The unlock key is the byte sequence C5h, 3Ah, A3h, 5Ch, C5h, 3Ah, A3h, 5Ch. Each byte is sent least significant bit first and byte C5h goes first. Key bit i is therefore bit i of 64'h5CA33AC55CA33AC5. Key bit i is compared with `cyc_d0` of the i-th counted write.
- R3: A counted write whose `cyc_d0` differs from the expected key bit locks recognition. Every later write is then ignored, even a write carrying the complete key, until an in-window read occurs.
- R4: An in-window read cycle during recognition returns the key pointer to bit 0 and clears the lockout. A key begun before that read cannot complete after it.
- R5: Only cycles whose address is below 80000h (address bits 20..19 zero) are counted. Cycles outside that window are ignored in every phase: they never move the key pointer, never advance the transfer and never raise `mem_inhibit`.
- R6: Before the full key has matched, `mem_inhibit` stays low for every cycle, including the key writes.
- R7: The write carrying key bit 63 captures `clk_image_in` into the shadow. During transfer, an in-window read returns shadow bit n on `rd_bit` in the same cycle as the strobe, where n is the number of transfer cycles already done. Bit 0 is bit 0 of register 0 (`clk_image_in[7:0]`).
- R8: During transfer, each of the 64 in-window cycles, read or write, raises `mem_inhibit` in the strobe cycle. An in-window write stores `cyc_d0` into shadow bit n.
- R9: The clock edge that ends the 64th transfer cycle makes `load_stb` high for exactly one cycle. At that edge `image_out` takes the final shadow. `byte_mask` bit k is set only if all eight bits of byte k were written during the transfer.
- R10: After the commit the block is waiting for the key again. The next in-window cycle goes to memory, and a fresh 64-bit key is needed to reach the shadow again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_rd | input | 1 | One-clock strobe marking a bus read cycle |
| cyc_wr | input | 1 | One-clock strobe marking a bus write cycle |
| cyc_addr | input | 21 | Address of the current bus cycle |
| cyc_d0 | input | 1 | Data bit 0 of the current write cycle |
| clk_image_in | input | 64 | Live clock register contents, register k in bits 8k+7..8k |
| mem_inhibit | output | 1 | High when the current cycle is taken from memory |
| rd_bit | output | 1 | Serial bit returned for a transfer read cycle |
| image_out | output | 64 | Shadow contents presented for commit |
| byte_mask | output | 8 | Bytes of `image_out` that were fully written |
| load_stb | output | 1 | One-cycle commit strobe for the clock core |

## Verification
The assertions assume that `cyc_rd` and `cyc_wr` are never high in the same clock. They also assume that the strobes are single-cycle events whose address and data are valid only while a strobe is high. The bench drives each bus cycle as one strobe at a time and drops it again after the following edge. Out-of-window traffic is mixed into key and transfer sequences at several points, with data bits chosen to break the key if they were counted. Transfers sweep the written byte over each of the eight positions and also mix writes and reads inside one byte.

// File: rtl/unlock_seq_pkg.sv
// Shared constants for the pattern-unlock sequencer.
// Assumes a 64-bit key and a 64-bit register image split into bytes.
package unlock_seq_pkg;
    localparam int SEQ_BITS = 64;
    localparam int PTR_W    = $clog2(SEQ_BITS);
    localparam int NBYTES   = SEQ_BITS / 8;
    // Bit i is the i-th bit expected on data bit 0 (bytes sent LSB first).
    localparam logic [SEQ_BITS-1:0] UNLOCK_KEY = {2{32'h5CA3_3AC5}};
endpackage

// File: rtl/unlock_key_matcher.sv
// Serial key comparator: walks a pointer through UNLOCK_KEY on counted
// writes, locks on the first mismatch, restarts on a counted read.
// Assumes rd_hit and wr_hit are never high together; idle while !active.
module unlock_key_matcher
    import unlock_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             rd_hit,
    input  logic             wr_hit,
    input  logic             d0,
    output logic [PTR_W-1:0] ptr,
    output logic             locked,
    output logic             key_done
);
    logic bit_ok;

    // Compare the incoming bit against the key bit under the pointer.
    always_comb begin
        bit_ok   = (d0 == UNLOCK_KEY[ptr]);
        key_done = active && wr_hit && !locked && bit_ok
                   && (ptr == PTR_W'(SEQ_BITS - 1));
    end

    // Pointer and lockout state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            locked <= 1'b0;
        end else if (!active || rd_hit) begin
            ptr    <= '0;
            locked <= 1'b0;
        end else if (wr_hit && !locked) begin
            if (!bit_ok)
                locked <= 1'b1;
            else if (key_done)
                ptr <= '0;
            else
                ptr <= PTR_W'(ptr + 1'b1);
        end
    end
endmodule

// File: rtl/unlock_xfer_shifter.sv
// Transfer engine: holds the 64-bit shadow, serves one bit per counted
// cycle, tracks written bits and commits the shadow with a full-byte mask
// after the last cycle. Assumes capture and active never overlap.
module unlock_xfer_shifter
    import unlock_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                active,
    input  logic                rd_hit,
    input  logic                wr_hit,
    input  logic                d0,
    input  logic [SEQ_BITS-1:0] img_in,
    output logic                rd_bit,
    output logic                last,
    output logic [SEQ_BITS-1:0] image_out,
    output logic [NBYTES-1:0]   byte_mask,
    output logic                load_stb
);
    logic [SEQ_BITS-1:0] shadow_q, shadow_nx;
    logic [SEQ_BITS-1:0] wmask_q, wmask_nx;
    logic [PTR_W-1:0]    bcnt_q;
    logic [NBYTES-1:0]   full_byte;
    logic                step;

    // Next shadow and written-bit mask for the current cycle.
    always_comb begin
        step      = active && (rd_hit || wr_hit);
        last      = step && (bcnt_q == PTR_W'(SEQ_BITS - 1));
        rd_bit    = active && rd_hit && shadow_q[bcnt_q];
        shadow_nx = shadow_q;
        wmask_nx  = wmask_q;
        if (active && wr_hit) begin
            shadow_nx[bcnt_q] = d0;
            wmask_nx[bcnt_q]  = 1'b1;
        end
    end

    // One mask bit per byte, set when every bit of the byte was written.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign full_byte[k] = &wmask_nx[8*k +: 8];
    end

    // Shadow capture, bit stepping and commit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q  <= '0;
            wmask_q   <= '0;
            bcnt_q    <= '0;
            image_out <= '0;
            byte_mask <= '0;
            load_stb  <= 1'b0;
        end else begin
            load_stb <= last;
            if (capture) begin
                shadow_q <= img_in;
                wmask_q  <= '0;
                bcnt_q   <= '0;
            end else if (step) begin
                shadow_q <= shadow_nx;
                wmask_q  <= wmask_nx;
                bcnt_q   <= PTR_W'(bcnt_q + 1'b1);
            end
            if (last) begin
                image_out <= shadow_nx;
                byte_mask <= full_byte;
            end
        end
    end
endmodule

// File: rtl/pattern_unlock_seq.sv
// Top: qualifies bus strobes against the key window, runs the key matcher
// while idle and the transfer engine after a full match.
// Assumes single-cycle strobes, never a read and a write in one clock.
module pattern_unlock_seq
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int WIN_W  = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_rd,
    input  logic                cyc_wr,
    input  logic [ADDR_W-1:0]   cyc_addr,
    input  logic                cyc_d0,
    input  logic [SEQ_BITS-1:0] clk_image_in,
    output logic                mem_inhibit,
    output logic                rd_bit,
    output logic [SEQ_BITS-1:0] image_out,
    output logic [NBYTES-1:0]   byte_mask,
    output logic                load_stb
);
    localparam int HI_W = ADDR_W - WIN_W;

    logic             in_win, rd_hit, wr_hit;
    logic             xfer_q, key_done, xfer_last, key_locked;
    logic [PTR_W-1:0] key_ptr;

    // Only cycles in the low address window take part.
    always_comb begin
        in_win      = (cyc_addr[ADDR_W-1 -: HI_W] == '0);
        rd_hit      = cyc_rd && in_win;
        wr_hit      = cyc_wr && in_win;
        mem_inhibit = xfer_q && (rd_hit || wr_hit);
    end

    // Phase flag: set by a full key match, cleared by the last transfer cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            xfer_q <= 1'b0;
        else if (key_done)
            xfer_q <= 1'b1;
        else if (xfer_last)
            xfer_q <= 1'b0;
    end

    unlock_key_matcher u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (!xfer_q),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit),
        .d0       (cyc_d0),
        .ptr      (key_ptr),
        .locked   (key_locked),
        .key_done (key_done)
    );

    unlock_xfer_shifter u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (key_done),
        .active    (xfer_q),
        .rd_hit    (rd_hit),
        .wr_hit    (wr_hit),
        .d0        (cyc_d0),
        .img_in    (clk_image_in),
        .rd_bit    (rd_bit),
        .last      (xfer_last),
        .image_out (image_out),
        .byte_mask (byte_mask),
        .load_stb  (load_stb)
    );
endmodule

// File: rtl/unlock_seq_checker.sv
// Protocol checks for pattern_unlock_seq, attached by bind.
// Assumes cyc_rd and cyc_wr are exclusive single-cycle strobes.
module unlock_seq_checker
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int WIN_W  = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_rd,
    input logic              cyc_wr,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic              xfer,
    input logic [PTR_W-1:0]  ptr,
    input logic              locked,
    input logic              mem_inhibit,
    input logic              rd_bit,
    input logic              load_stb
);
    logic out_win;
    assign out_win = (cyc_addr[ADDR_W-1:WIN_W] != '0);

    a_r4_read_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_rd && !out_win && !xfer) |=> (ptr == '0 && !locked));

    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !xfer && !(cyc_rd && !out_win)) |=> (locked && $stable(ptr)));

    a_r5_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_rd || cyc_wr) && out_win) |-> !mem_inhibit);

    a_r5_outside_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_rd || cyc_wr) && out_win && !xfer) |=> $stable(ptr));

    a_r6_no_inhibit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |-> (!mem_inhibit && !rd_bit));

    a_r7_entry_after_full_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && $past(rst_n)) |=> (!xfer || $past(ptr) == PTR_W'(SEQ_BITS - 1)));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    a_r10_idle_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (!xfer && ptr == '0 && !locked));
endmodule

bind pattern_unlock_seq unlock_seq_checker #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_rd      (cyc_rd),
    .cyc_wr      (cyc_wr),
    .cyc_addr    (cyc_addr),
    .xfer        (xfer_q),
    .ptr         (key_ptr),
    .locked      (key_locked),
    .mem_inhibit (mem_inhibit),
    .rd_bit      (rd_bit),
    .load_stb    (load_stb)
);

// File: tb/pattern_unlock_seq_tb_top.sv
// Self-checking bench: key entry, lockout, abort, window filtering and
// transfer sweeps with expected images computed in the bench.
module pattern_unlock_seq_tb_top;
    localparam logic [63:0] KEY   = 64'h5CA33AC55CA33AC5;
    localparam logic [20:0] A_IN  = 21'h00123;
    localparam logic [20:0] A_OUT = 21'h180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_rd = 1'b0, cyc_wr = 1'b0, cyc_d0 = 1'b0;
    logic [20:0] cyc_addr = '0;
    logic [63:0] clk_image_in = 64'h0;
    logic        mem_inhibit, rd_bit, load_stb;
    logic [63:0] image_out;
    logic [7:0]  byte_mask;

    int  checks = 0, fails = 0;
    bit  finished = 1'b0;
    logic s_inh, s_bit;

    always #5 clk = ~clk;

    pattern_unlock_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_rd(cyc_rd), .cyc_wr(cyc_wr),
        .cyc_addr(cyc_addr), .cyc_d0(cyc_d0), .clk_image_in(clk_image_in),
        .mem_inhibit(mem_inhibit), .rd_bit(rd_bit), .image_out(image_out),
        .byte_mask(byte_mask), .load_stb(load_stb)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One bus cycle: strobe from negedge to just past the next posedge.
    task automatic do_cyc(input logic r, input logic w, input logic [20:0] a, input logic d);
        @(negedge clk);
        cyc_rd = r; cyc_wr = w; cyc_addr = a; cyc_d0 = d;
        #1;
        s_inh = mem_inhibit;
        s_bit = rd_bit;
        @(posedge clk);
        #1;
        cyc_rd = 1'b0; cyc_wr = 1'b0;
    endtask

    // Send key bits [0..n-1]; bit flipped at index bad; out-of-window noise every 7 bits.
    task automatic send_key(input int n, input int bad, input bit noise);
        bit inh_seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (noise && (i % 7 == 3)) begin
                do_cyc(1'b0, 1'b1, A_OUT, ~KEY[i]);
                inh_seen |= s_inh;
                do_cyc(1'b1, 1'b0, A_OUT, 1'b0);
                inh_seen |= s_inh;
            end
            do_cyc(1'b0, 1'b1, A_IN, KEY[i] ^ (i == bad));
            inh_seen |= s_inh;
        end
        chk(!inh_seen, "R6 no inhibit during key", 64'(inh_seen), 64'h0);
    endtask

    // 64 transfer cycles: wsel bit = write, wdat = data; checks reads and inhibit,
    // then the commit strobe, image and byte mask.
    task automatic run_xfer(input logic [63:0] img, input logic [63:0] wsel,
                            input logic [63:0] wdat, input bit noise, input string tag);
        logic [63:0] exp_img = img;
        logic [7:0]  exp_mask;
        bit rd_bad = 1'b0, inh_bad = 1'b0;
        for (int n = 0; n < 64; n++) begin
            if (noise && (n % 9 == 4)) begin
                do_cyc(1'b1, 1'b0, A_OUT, 1'b0);
                inh_bad |= s_inh;
            end
            if (wsel[n]) begin
                do_cyc(1'b0, 1'b1, A_IN, wdat[n]);
                exp_img[n] = wdat[n];
            end else begin
                do_cyc(1'b1, 1'b0, A_IN, 1'b0);
                if (s_bit !== img[n]) rd_bad = 1'b1;
            end
            if (s_inh !== 1'b1) inh_bad = 1'b1;
            if (n < 63) chk(load_stb === 1'b0, "R9 no early commit", 64'(load_stb), 64'h0);
        end
        for (int k = 0; k < 8; k++) exp_mask[k] = &wsel[8*k +: 8];
        chk(!rd_bad, {"R7 serial read bits ", tag}, 64'(rd_bad), 64'h0);
        chk(!inh_bad, {"R8 inhibit on transfer cycles ", tag}, 64'(inh_bad), 64'h0);
        chk(load_stb === 1'b1, {"R9 load strobe ", tag}, 64'(load_stb), 64'h1);
        chk(image_out === exp_img, {"R9 committed image ", tag}, image_out, exp_img);
        chk(byte_mask === exp_mask, {"R9 byte mask ", tag}, 64'(byte_mask), 64'(exp_mask));
        @(posedge clk); #1;
        chk(load_stb === 1'b0, {"R9 strobe one cycle ", tag}, 64'(load_stb), 64'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        chk(mem_inhibit === 0 && rd_bit === 0 && load_stb === 0 && image_out === 0 && byte_mask === 0,
            "R1 reset outputs", {image_out[31:0], 21'h0, byte_mask, mem_inhibit, rd_bit, load_stb}, 64'h0);
        rst_n = 1'b1;

        // R2/R7: plain key then full read-out
        clk_image_in = 64'h0123_4567_89AB_CDEF;
        send_key(64, -1, 1'b0);
        clk_image_in = 64'hFFFF_0000_FFFF_0000; // later change must not leak in
        run_xfer(64'h0123_4567_89AB_CDEF, 64'h0, 64'h0, 1'b0, "R2 read all");

        // R10: first in-window cycle after commit goes to memory
        do_cyc(1'b0, 1'b1, A_IN, 1'b1);
        chk(s_inh === 1'b0, "R10 idle after commit", 64'(s_inh), 64'h0);
        do_cyc(1'b1, 1'b0, A_IN, 1'b0);

        // R5: key and transfer with out-of-window noise, full write
        clk_image_in = 64'hA5A5_5A5A_C3C3_3C3C;
        send_key(64, -1, 1'b1);
        run_xfer(64'hA5A5_5A5A_C3C3_3C3C, {64{1'b1}}, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, "R5 noise write all");

        // R3: mismatch at bit 10 then a whole correct key stays locked
        do_cyc(1'b1, 1'b0, A_IN, 1'b0);
        send_key(11, 10, 1'b0);
        send_key(64, -1, 1'b0);
        do_cyc(1'b0, 1'b1, A_IN, 1'b0);
        chk(s_inh === 1'b0, "R3 locked key ignored", 64'(s_inh), 64'h0);

        // R4: read clears the lock, then a full key unlocks
        do_cyc(1'b1, 1'b0, A_IN, 1'b0);
        clk_image_in = 64'h1111_2222_3333_4444;
        send_key(64, -1, 1'b0);
        run_xfer(64'h1111_2222_3333_4444, 64'h0000_00F0_FFFF_FFFF, 64'h0000_0050_CAFE_BABE, 1'b0, "R4 mixed");

        // R4: 30 bits, in-window read aborts, remaining 34 must not unlock
        do_cyc(1'b1, 1'b0, A_IN, 1'b0);
        send_key(30, -1, 1'b0);
        do_cyc(1'b1, 1'b0, A_IN, 1'b0);
        chk(s_inh === 1'b0, "R4 abort read to memory", 64'(s_inh), 64'h0);
        for (int i = 30; i < 64; i++) do_cyc(1'b0, 1'b1, A_IN, KEY[i]);
        do_cyc(1'b0, 1'b1, A_IN, 1'b0);
        chk(s_inh === 1'b0, "R4 partial key after abort", 64'(s_inh), 64'h0);

        // R5: out-of-window read mid-key does not abort
        do_cyc(1'b1, 1'b0, A_IN, 1'b0);
        send_key(20, -1, 1'b0);
        do_cyc(1'b1, 1'b0, A_OUT, 1'b0);
        for (int i = 20; i < 64; i++) do_cyc(1'b0, 1'b1, A_IN, KEY[i]);
        do_cyc(1'b1, 1'b0, A_IN, 1'b0);
        chk(s_inh === 1'b1 && s_bit === clk_image_in[0], "R5 outside read no abort",
            {62'h0, s_inh, s_bit}, {62'h0, 1'b1, clk_image_in[0]});
        for (int i = 1; i < 64; i++) do_cyc(1'b1, 1'b0, A_IN, 1'b0);
        @(posedge clk); #1;

        // R9 sweep: one fully written byte per run, plus a half-written byte
        for (int k = 0; k < 8; k++) begin
            logic [63:0] sel, dat;
            sel = 64'hFF << (8*k);
            sel[(8*((k+1)%8)) +: 4] = 4'hF;
            dat = {8{8'(8'h3C ^ 8'(k))}};
            clk_image_in = {8{8'(k * 17)}} ^ 64'h0F0F_F0F0_0F0F_F0F0;
            do_cyc(1'b1, 1'b0, A_IN, 1'b0);
            send_key(64, -1, (k % 2) == 1);
            run_xfer(clk_image_in, sel, dat, (k % 3) == 0, "R8 byte sweep");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule